// File: doc/BRIEF.md
# System Tick Timer with Register Access

A down-counting periodic timer reached through a small 32-bit register port. Each cycle the port may carry one request: a valid strobe, a write flag, a byte offset, write data and a privilege bit. Read data and an error flag come back combinationally in the same cycle. Side effects happen at the clock edge that ends the request cycle. The timer counts either on every core clock or only in cycles where an external reference tick input is high. Each time it passes through zero it reloads. It also latches a sticky count flag and, when the interrupt enable is set, emits a one-cycle interrupt pulse.

The counter is driven by a three-state machine. ST_IDLE means disabled with no held count. ST_RUN means enabled and counting. ST_HOLD means disabled with the count frozen. The transitions are:
- ST_IDLE to ST_RUN on an enable write, which loads the counter from the reload register.
- ST_RUN to ST_HOLD on a disable write.
- ST_HOLD to ST_RUN on an enable write, which resumes from the held count.
- ST_HOLD to ST_IDLE on a current-value write, which discards the held count.
- ST_RUN to ST_IDLE on a terminal event while the reload register is zero.

Software polls the count flag by reading the control register. That read also clears the flag. Writing the current-value register restarts the period.

Top module: `tick_timer`

## Requirements
- R1: After reset the control, reload and current-value registers read 0 and `irq` is low.
- R2: Offsets are 0x0 control, 0x4 reload, 0x8 current value and 0xC calibration. Control bits are: bit 0 enable, bit 1 interrupt enable, bit 2 source select (read back as written) and bit 16 count flag, with all other bits reading 0. A control write changes only bits 2:0. The reload register keeps the low CNT_W bits of the write data, and its upper bits read 0.
- R3: An enable write (bit 0 = 1) from ST_IDLE loads the counter with the reload value. Each count tick in ST_RUN then lowers the counter by one. A current-value read returns the counter while running.
- R4: A count tick in ST_RUN that finds the counter at 0 is a terminal event. It reloads the counter and sets the count flag, so one period is reload+1 count ticks.
- R5: After a terminal event, `irq` is high for exactly the one cycle following that edge if interrupt enable was 1, and stays low otherwise.
- R6: A control read returns the flag and clears it. A terminal event in the same cycle keeps the flag set.
- R7: A write to the current-value register clears the count flag. In ST_RUN it also reloads the counter, and no count tick is applied in that cycle.
- R8: A terminal event while reload is 0 clears the enable bit and the timer goes to ST_IDLE.
- R9: With source select 1 the timer counts on every clock. With source select 0 it counts only in cycles where `ext_tick` is 1. A control write that toggles the source select but leaves enable unchanged reloads the counter while running.
- R10: A disable write (bit 0 = 0) freezes the count. Current-value reads return 0 while disabled, and re-enabling resumes from the held count. A current-value write while held discards the count, so the next enable reloads.
- R11: The calibration register reads 10000. Other offsets read 0, and writes to them have no effect.
- R12: A request with `req_priv` = 0 returns `rsp_err` = 1 and read data 0, and changes no state; for example, it does not clear the count flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| req_priv | input | 1 | 1 = privileged request |
| ext_tick | input | 1 | Reference tick qualifier used when source select is 0 |
| rsp_rdata | output | 32 | Read data, valid in the request cycle |
| rsp_err | output | 1 | Error response for an unprivileged request |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Directed sequences walk each state transition:
- Short periods on the core clock show the reload+1 period length.
- A sparse reference tick separates the two clock sources.
- Freeze-and-resume shows a held count, distinguished from a fresh reload.
- A zero reload shows the stop.

A long constrained-random phase then mixes control, reload and current-value writes with flag reads, unprivileged requests and random reference ticks. Small reload values make terminal events coincide with register accesses, which checks write-over-tick precedence and the rule that a terminal event beats a flag clear in the same cycle.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_HOLD
    } tmr_state_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_RELOAD,
        SEL_CURRENT,
        SEL_CALIB
    } reg_sel_e;

    localparam int BIT_EN   = 0;
    localparam int BIT_TINT = 1;
    localparam int BIT_SRC  = 2;
    localparam int BIT_FLAG = 16;

endpackage

// File: rtl/tick_timer_decode.sv
module tick_timer_decode
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_priv,
    input  logic [ADDR_W-1:0] req_addr,
    output reg_sel_e          sel,
    output logic              acc_ok,
    output logic              rsp_err,
    output logic              ctl_we,
    output logic              ctl_re,
    output logic              rld_we,
    output logic              cur_we
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(4'h0);
    localparam logic [ADDR_W-1:0] A_RLD  = ADDR_W'(4'h4);
    localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(4'h8);
    localparam logic [ADDR_W-1:0] A_CAL  = ADDR_W'(4'hC);

    always_comb begin
        case (req_addr)
            A_CTRL:  sel = SEL_CTRL;
            A_RLD:   sel = SEL_RELOAD;
            A_CUR:   sel = SEL_CURRENT;
            A_CAL:   sel = SEL_CALIB;
            default: sel = SEL_NONE;
        endcase
    end

    assign acc_ok  = req_valid && req_priv;
    assign rsp_err = req_valid && !req_priv;
    assign ctl_we  = acc_ok && req_write  && (sel == SEL_CTRL);
    assign ctl_re  = acc_ok && !req_write && (sel == SEL_CTRL);
    assign rld_we  = acc_ok && req_write  && (sel == SEL_RELOAD);
    assign cur_we  = acc_ok && req_write  && (sel == SEL_CURRENT);

endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             wr_en,
    input  logic             wr_src,
    input  logic             cur_we,
    input  logic             src_sel,
    input  logic             tickint,
    input  logic [CNT_W-1:0] reload,
    input  logic             ext_tick,
    output logic             running,
    output logic [CNT_W-1:0] count,
    output logic             terminal,
    output logic             irq
);
    tmr_state_e       state, state_nxt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             tick, en_on, en_off, src_flip;

    assign tick     = src_sel || ext_tick;
    assign en_on    = ctl_we && wr_en;
    assign en_off   = ctl_we && !wr_en;
    assign src_flip = ctl_we && (wr_src != src_sel);
    assign running  = (state == ST_RUN);

    always_comb begin
        state_nxt = state;
        cnt_nxt   = count;
        terminal  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (en_on) begin
                    state_nxt = ST_RUN;
                    cnt_nxt   = reload;
                end
            end
            ST_HOLD: begin
                if (en_on) begin
                    state_nxt = ST_RUN;
                end else if (cur_we) begin
                    state_nxt = ST_IDLE;
                    cnt_nxt   = '0;
                end
            end
            ST_RUN: begin
                if (en_off) begin
                    state_nxt = ST_HOLD;
                end else if (cur_we || src_flip) begin
                    cnt_nxt = reload;
                end else if (tick) begin
                    if (count == '0) begin
                        terminal = 1'b1;
                        cnt_nxt  = reload;
                        if (reload == '0) begin
                            state_nxt = ST_IDLE;
                        end
                    end else begin
                        cnt_nxt = count - 1'b1;
                    end
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            count <= '0;
        end else begin
            state <= state_nxt;
            count <= cnt_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= terminal && tickint;
        end
    end

    AST_ENABLE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && en_on) |=> (running && count == $past(reload))); // R3

    AST_ZERO_RELOAD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (terminal && reload == '0) |=> !running); // R8

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !cur_we) |=> $stable(count)); // R10

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R5

    AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !ctl_we && !cur_we && !src_sel && !ext_tick) |=> $stable(count)); // R9

endmodule

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
    import tick_timer_pkg::*;
#(
    parameter int          CNT_W     = 24,
    parameter logic [31:0] CAL_VALUE = 32'd10000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  reg_sel_e         sel,
    input  logic             acc_ok,
    input  logic             req_write,
    input  logic             rsp_err,
    input  logic             ctl_we,
    input  logic             ctl_re,
    input  logic             rld_we,
    input  logic             cur_we,
    input  logic             wr_tint,
    input  logic             wr_src,
    input  logic [CNT_W-1:0] wr_reload,
    input  logic             running,
    input  logic [CNT_W-1:0] count,
    input  logic             terminal,
    output logic             tickint,
    output logic             src_sel,
    output logic [CNT_W-1:0] reload,
    output logic [31:0]      rdata
);
    logic flag;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tickint <= 1'b0;
            src_sel <= 1'b0;
            reload  <= '0;
            flag    <= 1'b0;
        end else begin
            if (ctl_we) begin
                tickint <= wr_tint;
                src_sel <= wr_src;
            end
            if (rld_we) begin
                reload <= wr_reload;
            end
            if (terminal) begin
                flag <= 1'b1;
            end else if (ctl_re || cur_we) begin
                flag <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (acc_ok && !req_write) begin
            case (sel)
                SEL_CTRL: begin
                    rdata[BIT_EN]   = running;
                    rdata[BIT_TINT] = tickint;
                    rdata[BIT_SRC]  = src_sel;
                    rdata[BIT_FLAG] = flag;
                end
                SEL_RELOAD:  rdata = 32'(reload);
                SEL_CURRENT: rdata = running ? 32'(count) : 32'd0;
                SEL_CALIB:   rdata = CAL_VALUE;
                default:     rdata = '0;
            endcase
        end
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        terminal |=> flag); // R4

    AST_FLAG_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_re && !terminal) |=> !flag); // R6

    AST_UNPRIV_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_err && !terminal) |=> ($stable(reload) && $stable(tickint)
                                    && $stable(src_sel) && $stable(flag))); // R12

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          CNT_W     = 24,
    parameter logic [31:0] CAL_VALUE = 32'd10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              req_priv,
    input  logic              ext_tick,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              irq
);
    reg_sel_e         sel;
    logic             acc_ok, ctl_we, ctl_re, rld_we, cur_we;
    logic             running, terminal, tickint, src_sel;
    logic [CNT_W-1:0] count, reload;
    logic             unused_wdata;

    assign unused_wdata = ^req_wdata;

    tick_timer_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_priv  (req_priv),
        .req_addr  (req_addr),
        .sel       (sel),
        .acc_ok    (acc_ok),
        .rsp_err   (rsp_err),
        .ctl_we    (ctl_we),
        .ctl_re    (ctl_re),
        .rld_we    (rld_we),
        .cur_we    (cur_we)
    );

    tick_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_we   (ctl_we),
        .wr_en    (req_wdata[BIT_EN]),
        .wr_src   (req_wdata[BIT_SRC]),
        .cur_we   (cur_we),
        .src_sel  (src_sel),
        .tickint  (tickint),
        .reload   (reload),
        .ext_tick (ext_tick),
        .running  (running),
        .count    (count),
        .terminal (terminal),
        .irq      (irq)
    );

    tick_timer_regs #(.CNT_W(CNT_W), .CAL_VALUE(CAL_VALUE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .acc_ok    (acc_ok),
        .req_write (req_write),
        .rsp_err   (rsp_err),
        .ctl_we    (ctl_we),
        .ctl_re    (ctl_re),
        .rld_we    (rld_we),
        .cur_we    (cur_we),
        .wr_tint   (req_wdata[BIT_TINT]),
        .wr_src    (req_wdata[BIT_SRC]),
        .wr_reload (req_wdata[CNT_W-1:0]),
        .running   (running),
        .count     (count),
        .terminal  (terminal),
        .tickint   (tickint),
        .src_sel   (src_sel),
        .reload    (reload),
        .rdata     (rsp_rdata)
    );

endmodule

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;
    localparam real      CLK_NS = 8.0;
    localparam bit [31:0] CMASK = 32'h00FF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0, ext_tick = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_err, irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    bit          m_en, m_held, m_tint, m_src, m_flag, m_irq;
    int unsigned m_cnt, m_rld;

    always #(CLK_NS/2) clk = ~clk;

    tick_timer uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_priv(req_priv),
        .ext_tick(ext_tick), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq(irq)
    );

    task automatic chk(input string tag, input logic [32:0] act, input logic [32:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00:   return (32'(m_flag) << 16) | (32'(m_src) << 2) | (32'(m_tint) << 1) | 32'(m_en);
            8'h04:   return m_rld;
            8'h08:   return m_en ? m_cnt : 32'd0;
            8'h0C:   return 32'd10000;
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_tick(output bit term);
        term = 1'b0;
        if (m_cnt == 0) begin
            term = 1'b1;
            if (m_rld == 0) begin
                m_en = 1'b0; m_held = 1'b0; m_cnt = 0;
            end else begin
                m_cnt = m_rld;
            end
        end else begin
            m_cnt = m_cnt - 1;
        end
    endtask

    task automatic model_step(input bit v, input bit w, input logic [7:0] a,
                              input logic [31:0] d, input bit p, input bit x);
        bit ok, tk, term, old_tint;
        ok = v && p;
        tk = m_src || x;
        term = 1'b0;
        old_tint = m_tint;
        if (ok && w && a == 8'h00) begin
            if (!m_en && d[0]) begin
                if (!m_held) m_cnt = m_rld;
                m_en = 1'b1;
            end else if (m_en && !d[0]) begin
                m_en = 1'b0; m_held = 1'b1;
            end else if (m_en && d[2] != m_src) begin
                m_cnt = m_rld;
            end else if (m_en && tk) begin
                model_tick(term);
            end
            m_tint = d[1];
            m_src  = d[2];
        end else if (ok && w && a == 8'h08) begin
            if (m_en) m_cnt = m_rld;
            else begin m_held = 1'b0; m_cnt = 0; end
        end else if (m_en && tk) begin
            model_tick(term);
        end
        if (ok && w && a == 8'h04) m_rld = d & CMASK;
        if (term) m_flag = 1'b1;
        else if (ok && ((!w && a == 8'h00) || (w && a == 8'h08))) m_flag = 1'b0;
        m_irq = term && old_tint;
    endtask

    task automatic cyc(input bit v, input bit w, input logic [7:0] a, input logic [31:0] d,
                       input bit p, input bit x, input string tag);
        logic [31:0] er;
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; req_wdata = d; req_priv = p; ext_tick = x;
        #1;
        if (v) begin
            er = (!p || w) ? 32'd0 : model_read(a);
            chk(tag, {rsp_err, rsp_rdata}, {!p, er});
        end
        model_step(v, w, a, d, p, x);
        @(posedge clk);
        #1;
        if (m_irq || irq) chk("R5 irq", {32'd0, irq}, {32'd0, m_irq});
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        cyc(1, 0, a, 0, 1, 0, tag);
    endtask
    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        cyc(1, 1, a, d, 1, 0, tag);
    endtask
    task automatic idle(input int n, input bit x);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1, x, "idle");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_fail++;
        n_run++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int r;
        logic [31:0] d;
        void'($urandom(32'd20240611));
        m_en = 0; m_held = 0; m_tint = 0; m_src = 0; m_flag = 0; m_irq = 0;
        m_cnt = 0; m_rld = 0;
        repeat (4) @(negedge clk);
        chk("R1 irq in reset", {32'd0, irq}, 33'd0);
        rst_n = 1'b1;

        rd(8'h00, "R1 ctrl"); rd(8'h04, "R1 reload"); rd(8'h08, "R1 current");

        wr(8'h04, 32'hFFFF_FFFF, "R2"); rd(8'h04, "R2 reload width");
        wr(8'h00, 32'hFFFF_FFF8, "R2"); rd(8'h00, "R2 upper ctrl bits ignored");
        wr(8'h00, 32'h0000_0006, "R2"); rd(8'h00, "R2 field positions");

        rd(8'h0C, "R11 calib");
        wr(8'h10, 32'h1234_5678, "R11"); rd(8'h10, "R11 unmapped");
        wr(8'h02, 32'h1, "R11"); rd(8'h00, "R11 misaligned write ignored");
        rd(8'h04, "R11 reload intact");

        cyc(1, 1, 8'h04, 32'd5, 0, 0, "R12 unpriv write");
        rd(8'h04, "R12 reload unchanged");
        cyc(1, 0, 8'h0C, 0, 0, 0, "R12 unpriv read");

        wr(8'h04, 32'd3, "R3");
        wr(8'h00, 32'h7, "R3 enable");
        for (int i = 0; i < 10; i++) rd(8'h08, "R3 R4 countdown");
        rd(8'h00, "R6 flag read");
        rd(8'h00, "R6 flag cleared");
        idle(3, 0);
        cyc(1, 0, 8'h00, 0, 0, 0, "R12 unpriv ctrl read");
        rd(8'h00, "R12 flag kept");

        wr(8'h00, 32'h3, "R9 source flip reload");
        rd(8'h08, "R9 reloaded");
        idle(3, 0);
        rd(8'h08, "R9 no ref tick");
        idle(2, 1);
        rd(8'h08, "R9 ref ticks");
        wr(8'h00, 32'h7, "R9 back to core clock");

        idle(1, 0);
        wr(8'h00, 32'h6, "R10 disable");
        rd(8'h08, "R10 reads zero");
        idle(4, 0);
        wr(8'h00, 32'h7, "R10 resume");
        rd(8'h08, "R10 resumed value");
        idle(5, 0);

        wr(8'h04, 32'd6, "R7");
        idle(2, 0);
        wr(8'h08, 32'h0, "R7 current write");
        rd(8'h08, "R7 reloaded");
        rd(8'h00, "R7 flag cleared");

        wr(8'h00, 32'h6, "R10 disable");
        wr(8'h08, 32'h0, "R10 discard");
        wr(8'h00, 32'h7, "R10 fresh load");
        rd(8'h08, "R10 fresh value");

        wr(8'h04, 32'd0, "R8");
        idle(8, 0);
        rd(8'h00, "R8 stopped");
        rd(8'h08, "R8 current zero");

        for (int i = 0; i < 4000; i++) begin
            r = $urandom_range(0, 99);
            d = $urandom;
            if (r < 8)       wr(8'h00, {d[31:3], ($urandom_range(0, 3) != 0), d[1:0]} | (d[5] ? 32'h1 : 32'h0), "R9 random ctrl");
            else if (r < 16) wr(8'h04, $urandom_range(0, 6), "R4 random reload");
            else if (r < 20) wr(8'h08, d, "R7 random current");
            else if (r < 35) cyc(1, 0, 8'h00, 0, 1, d[7] & d[8], "R6 random flag");
            else if (r < 50) cyc(1, 0, 8'h08, 0, 1, d[7] & d[8], "R3 random current");
            else if (r < 53) rd(8'h04, "R2 random reload");
            else if (r < 57) cyc(1, d[0], {4'h0, d[3:2], 2'b00}, d, 0, d[9], "R12 random unpriv");
            else if (r < 59) rd({d[7:2], 2'b00}, "R11 random offset");
            else             cyc(0, 0, 0, 0, 1, d[7] & d[8], "idle");
        end
        idle(2, 0);
        finish_run();
    end
endmodule